// File: doc/BRIEF.md
# Framed Multi-Lane Audio Serial Transmitter

This block turns parallel PCM samples into serial audio. An external clock generator supplies two one-cycle strobes in the system clock domain. `bit_tick` marks each bit period. `frame_tick`, raised together with `bit_tick`, marks the first bit of a 64-bit frame. Each frame holds two 32-bit slots: the left channel comes first with `ws` low, then the right channel with `ws` high. Samples are sent MSB first. The alignment code decides where a sample sits inside its slot. The width bit picks 16 or 24 significant bits. The channel-mode bit chooses one stereo pair on lane 0, or four pairs on four lanes that share one word-select.

A whole frame of samples is taken at the frame edge through a valid/ready handshake. If no sample is offered at that edge, the frame is sent as zeros and a sticky underrun flag is set. A hold input silences the data lines while the word-select and the bit count keep running. A configuration check rejects illegal settings and keeps the data lines silent while they are applied. The split bit selects which half of each lane's 48-bit input field holds the left sample.

The controller has three states:
- HOLD: silent, nothing accepted.
- SYNC: released, waiting for a frame edge.
- RUN: streaming.

Its transitions are:
- `release` (HOLD→SYNC): hold is low and the configuration is legal.
- `lock` (SYNC→RUN): first frame edge.
- `stream` (RUN→RUN): a further frame edge loads the next frame.
- `silence` (SYNC/RUN→HOLD): hold is raised or the configuration becomes illegal.

The format fields are captured at each frame edge, so changes in the middle of a frame take effect at the next frame.

Top module: `i2s_tx`

## Requirements
- R1: After reset, `sd` is all zero, and `ws`, `in_ready`, `cfg_err` and `underrun` are 0.
- R2: A bit position advances only on `bit_tick`. Position 0 starts when `frame_tick` and `bit_tick` are high together. `ws` is 0 for positions 0–31 and 1 for positions 32–63, including while held.
- R3: With `cfg_align`=0 (left-justified), the sample MSB is at position 0 of its slot, followed by the lower bits in descending order.
- R4: With `cfg_align`=1 (I2S), the sample MSB is at position 1 of its slot, one bit after the slot edge.
- R5: With `cfg_align`=2 (right-justified), the sample LSB is at position 31 of its slot.
- R6: With `cfg_w24`=0, a sample is the low 16 bits of its 24-bit field. With `cfg_w24`=1, it is all 24 bits. Slot bits outside the sample are 0.
- R7: `cfg_err` is 1 when `cfg_w24`=1 with `cfg_slot32`=0, or when `cfg_align`=3. While `cfg_err` is 1, no sample is accepted and `sd` is 0.
- R8: From the cycle after `hold` is seen high, `sd` is 0 and no sample is accepted.
- R9: `in_ready` is high only in a cycle with both strobes high, while streaming is allowed. A sample is taken in that cycle, and its first bit appears on the next cycle.
- R10: If `in_valid` is 0 when `in_ready` is high, the frame is sent as zeros and `underrun` becomes 1 and stays 1 until reset.
- R11: With `cfg_mode8`=1, lane k (0..3) carries channel pair 2k/2k+1 from `in_data[48k+47:48k]`. With `cfg_mode8`=0, only lane 0 carries data and lanes 1–3 stay 0.
- R12: With `cfg_split`=1, the left sample is bits [23:0] and the right sample is bits [47:24] of a lane field. With `cfg_split`=0, the two halves swap roles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_tick | input | 1 | One-cycle strobe per bit period |
| frame_tick | input | 1 | High with `bit_tick` on the first bit of a frame |
| cfg_align | input | 2 | 0 left-justified, 1 I2S, 2 right-justified, 3 illegal |
| cfg_w24 | input | 1 | 1 selects 24-bit samples, 0 selects 16-bit |
| cfg_slot32 | input | 1 | 32-bit slot mode enable, required for 24-bit samples |
| cfg_mode8 | input | 1 | 1 selects eight channels on four lanes |
| cfg_split | input | 1 | Field ordering of left/right within each lane |
| hold | input | 1 | Silences the data lines |
| in_valid | input | 1 | Sample frame offered |
| in_ready | output | 1 | Sample frame taken this cycle |
| in_data | input | 192 | Four 48-bit lane fields |
| sd | output | 4 | Serial data, one bit per lane |
| ws | output | 1 | Word select: 0 left slot, 1 right slot |
| cfg_err | output | 1 | Illegal configuration present |
| underrun | output | 1 | Sticky missing-sample flag |

## Verification
Sample words with distinct, asymmetric bit patterns are sent under every alignment at both widths. An off-by-one placement, a reversed bit order, or a truncation error therefore changes the expected 64-bit stream. Both split orderings use left and right words that differ, so a left/right swap is visible. An eight-channel frame with a different pattern per lane, followed by a stereo frame, separates lane routing from stale lane data. Held frames, rejected settings and a frame with no valid sample each expect silent data with `ws` still toggling, which tells apart "clocks stopped" from "data muted".

// File: rtl/i2s_tx_pkg.sv
package i2s_tx_pkg;

    typedef enum logic [1:0] {
        ST_HOLD = 2'd0,
        ST_SYNC = 2'd1,
        ST_RUN  = 2'd2
    } tx_state_t;

    localparam logic [1:0] AL_LEFT  = 2'd0;
    localparam logic [1:0] AL_I2S   = 2'd1;
    localparam logic [1:0] AL_RIGHT = 2'd2;

    localparam int SLOT_BITS  = 32;
    localparam int POS_W      = 6;

    // number of significant bits carried in a slot
    function automatic logic [5:0] sample_len(input logic w24);
        return w24 ? 6'd24 : 6'd16;
    endfunction

    // slot position of the sample MSB
    function automatic logic [5:0] first_bit(input logic [1:0] al, input logic w24);
        logic [5:0] f;
        unique case (al)
            AL_LEFT:  f = 6'd0;
            AL_I2S:   f = 6'd1;
            AL_RIGHT: f = 6'(SLOT_BITS) - sample_len(w24);
            default:  f = 6'd0;
        endcase
        return f;
    endfunction

endpackage

// File: rtl/i2s_tx_ctrl.sv
module i2s_tx_ctrl
    import i2s_tx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_tick,
    input  logic             frame_tick,
    input  logic             hold,
    input  logic             cfg_bad,
    input  logic             in_valid,
    input  logic [1:0]       cfg_align,
    input  logic             cfg_w24,
    output logic             load,
    output logic             active,
    output logic [POS_W-1:0] pos,
    output logic [5:0]       first_q,
    output logic [5:0]       len_q,
    output logic             underrun
);

    tx_state_t state_q, state_d;
    logic      frame_edge;
    logic      go;

    assign frame_edge = bit_tick & frame_tick;
    assign go         = ~hold & ~cfg_bad;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HOLD: if (go)              state_d = ST_SYNC;
            ST_SYNC: if (!go)             state_d = ST_HOLD;
                     else if (frame_edge) state_d = ST_RUN;
            ST_RUN:  if (!go)             state_d = ST_HOLD;
            default:                      state_d = ST_HOLD;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_HOLD;
        else        state_q <= state_d;
    end

    // outputs of the state machine
    always_comb begin
        load   = 1'b0;
        active = 1'b0;
        unique case (state_q)
            ST_HOLD: ;
            ST_SYNC: load = frame_edge & go;
            ST_RUN: begin
                load   = frame_edge & go;
                active = 1'b1;
            end
            default: ;
        endcase
    end

    // bit position, captured format, underrun flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos      <= '0;
            first_q  <= '0;
            len_q    <= 6'd16;
            underrun <= 1'b0;
        end else begin
            if (bit_tick) begin
                if (frame_tick) pos <= '0;
                else            pos <= pos + 1'b1;
            end
            if (load) begin
                first_q <= first_bit(cfg_align, cfg_w24);
                len_q   <= sample_len(cfg_w24);
                if (!in_valid) underrun <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/i2s_tx_lane.sv
module i2s_tx_lane
    import i2s_tx_pkg::*;
#(
    parameter int MAXW = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [MAXW-1:0]  left_i,
    input  logic [MAXW-1:0]  right_i,
    input  logic             active,
    input  logic [POS_W-1:0] pos,
    input  logic [5:0]       first_q,
    input  logic [5:0]       len_q,
    output logic             sd
);

    localparam int IW = $clog2(MAXW);

    logic [MAXW-1:0] left_q, right_q;
    logic [MAXW-1:0] smp;
    int              qi, fi, wi, idx;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_q  <= '0;
            right_q <= '0;
        end else if (load) begin
            left_q  <= left_i;
            right_q <= right_i;
        end
    end

    // select the bit that belongs to the current slot position
    always_comb begin
        smp = pos[POS_W-1] ? right_q : left_q;
        qi  = int'(pos[POS_W-2:0]);
        fi  = int'(first_q);
        wi  = int'(len_q);
        idx = 0;
        sd  = 1'b0;
        if (active && qi >= fi && qi < fi + wi) begin
            idx = wi - 1 - (qi - fi);
            sd  = smp[idx[IW-1:0]];
        end
    end

endmodule

// File: rtl/i2s_tx.sv
module i2s_tx
    import i2s_tx_pkg::*;
#(
    parameter int LANES = 4,
    parameter int MAXW  = 24
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    bit_tick,
    input  logic                    frame_tick,
    input  logic [1:0]              cfg_align,
    input  logic                    cfg_w24,
    input  logic                    cfg_slot32,
    input  logic                    cfg_mode8,
    input  logic                    cfg_split,
    input  logic                    hold,
    input  logic                    in_valid,
    output logic                    in_ready,
    input  logic [LANES*2*MAXW-1:0] in_data,
    output logic [LANES-1:0]        sd,
    output logic                    ws,
    output logic                    cfg_err,
    output logic                    underrun
);

    localparam int FIELD_W = 2 * MAXW;
    localparam int NARROW  = 16;

    logic             load;
    logic             active;
    logic [POS_W-1:0] pos;
    logic [5:0]       first_q;
    logic [5:0]       len_q;
    logic [MAXW-1:0]  wmask;

    assign cfg_err  = (cfg_w24 & ~cfg_slot32) | (cfg_align == 2'd3);
    assign in_ready = load;
    assign ws       = pos[POS_W-1];
    assign wmask    = cfg_w24 ? {MAXW{1'b1}} : MAXW'({NARROW{1'b1}});

    i2s_tx_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_tick   (bit_tick),
        .frame_tick (frame_tick),
        .hold       (hold),
        .cfg_bad    (cfg_err),
        .in_valid   (in_valid),
        .cfg_align  (cfg_align),
        .cfg_w24    (cfg_w24),
        .load       (load),
        .active     (active),
        .pos        (pos),
        .first_q    (first_q),
        .len_q      (len_q),
        .underrun   (underrun)
    );

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic [FIELD_W-1:0] field;
        logic [MAXW-1:0]    lo, hi, l_d, r_d;
        logic               lane_en;

        assign field   = in_data[k*FIELD_W +: FIELD_W];
        assign lo      = field[MAXW-1:0] & wmask;
        assign hi      = field[FIELD_W-1:MAXW] & wmask;
        assign lane_en = in_valid & ((k == 0) | cfg_mode8);
        assign l_d     = lane_en ? (cfg_split ? lo : hi) : '0;
        assign r_d     = lane_en ? (cfg_split ? hi : lo) : '0;

        i2s_tx_lane #(.MAXW(MAXW)) u_lane (
            .clk     (clk),
            .rst_n   (rst_n),
            .load    (load),
            .left_i  (l_d),
            .right_i (r_d),
            .active  (active),
            .pos     (pos),
            .first_q (first_q),
            .len_q   (len_q),
            .sd      (sd[k])
        );
    end

endmodule

// File: rtl/i2s_tx_chk.sv
module i2s_tx_chk #(
    parameter int LANES = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bit_tick,
    input logic             frame_tick,
    input logic             hold,
    input logic             in_valid,
    input logic             in_ready,
    input logic [LANES-1:0] sd,
    input logic             ws,
    input logic             cfg_err,
    input logic             underrun
);

    p_ws_steady_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_tick |=> $stable(ws));

    p_bad_cfg_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cfg_err) |-> sd == '0);

    p_hold_silent_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(hold) |-> sd == '0);

    p_ready_edge_r9: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> (bit_tick && frame_tick && !hold && !cfg_err));

    p_underrun_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready && !in_valid) |=> underrun);

    p_underrun_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(underrun) |-> underrun);

endmodule

bind i2s_tx i2s_tx_chk #(.LANES(LANES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_tick   (bit_tick),
    .frame_tick (frame_tick),
    .hold       (hold),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .sd         (sd),
    .ws         (ws),
    .cfg_err    (cfg_err),
    .underrun   (underrun)
);

// File: tb/i2s_tx_test.sv
module i2s_tx_test;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bit_tick = 1'b0;
    logic         frame_tick = 1'b0;
    logic [1:0]   cfg_align = 2'd0;
    logic         cfg_w24 = 1'b0;
    logic         cfg_slot32 = 1'b1;
    logic         cfg_mode8 = 1'b0;
    logic         cfg_split = 1'b1;
    logic         hold = 1'b1;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [191:0] in_data = '0;
    logic [3:0]   sd;
    logic         ws;
    logic         cfg_err;
    logic         underrun;

    int tests = 0;
    int fails = 0;

    logic [255:0] exp_q[$];

    always #5 clk = ~clk;

    i2s_tx uut (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .frame_tick(frame_tick),
        .cfg_align(cfg_align), .cfg_w24(cfg_w24), .cfg_slot32(cfg_slot32),
        .cfg_mode8(cfg_mode8), .cfg_split(cfg_split), .hold(hold),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .sd(sd), .ws(ws), .cfg_err(cfg_err), .underrun(underrun)
    );

    task automatic check(input string req, input logic [63:0] got, input logic [63:0] expv);
        tests++;
        if (got !== expv) begin
            fails++;
            $display("FAIL %s got=%h exp=%h", req, got, expv);
        end
    endtask

    // model: 64-bit frame for one lane from a left/right pair
    function automatic logic [63:0] frame_model(input logic [1:0] al, input logic w24,
                                                input logic [23:0] l, input logic [23:0] r);
        logic [63:0] f = '0;
        int w = w24 ? 24 : 16;
        int st = (al == 2'd0) ? 0 : (al == 2'd1) ? 1 : 32 - w;
        for (int i = 0; i < w; i++) begin
            f[st + i]      = l[w - 1 - i];
            f[32 + st + i] = r[w - 1 - i];
        end
        return f;
    endfunction

    // driver: computes the expected lanes, then plays one frame
    task automatic run_frame(input logic [1:0] al, input logic w24, input logic s32,
                             input logic m8, input logic sp, input logic hd,
                             input logic vld, input logic [191:0] dat, input string req);
        logic [255:0] expv = '0;
        logic [255:0] gotv = '0;
        logic [63:0]  wsv = '0;
        logic [63:0]  ws_exp = {32'hFFFF_FFFF, 32'h0};
        logic         rdy = 1'b0;
        logic         bad = (w24 && !s32) || (al == 2'd3);
        logic         acc = !bad && !hd;
        @(negedge clk);
        cfg_align = al; cfg_w24 = w24; cfg_slot32 = s32; cfg_mode8 = m8;
        cfg_split = sp; hold = hd; in_valid = vld; in_data = dat;
        if (acc && vld) begin
            for (int k = 0; k < 4; k++) begin
                logic [47:0] fld = dat[k*48 +: 48];
                logic [23:0] lo = w24 ? fld[23:0]  : {8'h0, fld[15:0]};
                logic [23:0] hi = w24 ? fld[47:24] : {8'h0, fld[39:24]};
                if (k == 0 || m8)
                    expv[k*64 +: 64] = sp ? frame_model(al, w24, lo, hi)
                                          : frame_model(al, w24, hi, lo);
            end
        end
        exp_q.push_back(expv);
        for (int b = 0; b < 64; b++) begin
            @(negedge clk);
            bit_tick = 1'b1;
            frame_tick = (b == 0);
            #1;
            if (b == 0) rdy = in_ready;
            @(negedge clk);
            bit_tick = 1'b0;
            frame_tick = 1'b0;
            for (int k = 0; k < 4; k++) gotv[k*64 + b] = sd[k];
            wsv[b] = ws;
        end
        // monitor side: pop and compare
        expv = exp_q.pop_front();
        for (int k = 0; k < 4; k++) check(req, gotv[k*64 +: 64], expv[k*64 +: 64]);
        check("R2", wsv, ws_exp);
        check("R9", {63'b0, rdy}, {63'b0, acc});
        check("R7", {63'b0, cfg_err}, {63'b0, bad});
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [191:0] d2, d8;
        d2 = {144'h0, 24'h3C_96E1, 24'hA5_C3F1};
        d8 = {24'h123456, 24'h89ABCD, 24'hFEDCBA, 24'h765432,
              24'h0F1E2D, 24'hC3B4A5, 24'h5A6B7C, 24'hE1D2C3};
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", {56'b0, sd, ws, in_ready, cfg_err, underrun}, 64'h0);

        run_frame(2'd0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, d2, "R3");
        run_frame(2'd1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, d2, "R4");
        run_frame(2'd2, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, d2, "R5");
        run_frame(2'd0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, d2, "R6");
        run_frame(2'd1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, d2, "R6");
        run_frame(2'd2, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, d2, "R6");
        run_frame(2'd1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, d8, "R11");
        run_frame(2'd0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, d8, "R11");
        run_frame(2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, d2, "R12");
        run_frame(2'd2, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, d8, "R12");
        run_frame(2'd0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, d8, "R8");
        run_frame(2'd0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, d2, "R7");
        run_frame(2'd3, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, d2, "R7");
        check("R10", {63'b0, underrun}, 64'h0);
        run_frame(2'd1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, d2, "R10");
        check("R10", {63'b0, underrun}, 64'h1);
        run_frame(2'd1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, d2, "R9");
        check("R10", {63'b0, underrun}, 64'h1);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule